// File: doc/BRIEF.md
# TDM Frame-Sync Serial Transmitter

This block sends multichannel conversion results to a host over one or more serial data lines. It divides the master clock into a continuously running bit clock. For every conversion it emits one frame. The frame opens with a one-bit-wide frame-sync pulse. After the pulse, each data line shifts out several time-multiplexed channel packets, one after another.

The host presents all channel words in parallel together with a one-cycle ready strobe. The number of channels per line, the packet width and the clock divider are sampled only when a frame begins. A frame can run past the next conversion, either because the divider is too slow or because too many bits are requested. The block then latches a sticky overrun flag and keeps only the newest pending words.

Top module: `tdm_fsync_tx`

## Requirements
- R1: The bit clock `dclk` has a period of 2×D master clock cycles, where D is the divider value in force for the current frame. A divider value of 0 is treated as 1.
- R2: `dout` and `fsync` change only on master clock edges where `dclk` falls, so the host can sample them on the rising edge of `dclk`.
- R3: `cfg_tdm` selects the channels per line: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: `cfg_pkt` selects the packet length: 0 gives 24 bits and 1 gives 40 bits. A 24-bit packet carries bits 23..0 of its word, and bits 39..24 are ignored.
- R5: Line L carries slots 0, 1, … in ascending order. Slot S holds word L×8+S of `conv_data`, and word k sits at bits k×40+39..k×40. Each packet is sent MSB first.
- R6: `fsync` is high for exactly one `dclk` period, together with the first bit of a frame.
- R7: Outside a frame, and after reset, `dout` and `fsync` are low.
- R8: When no frame is shifting, a strobe on `conv_valid` starts a frame at the first `dclk` falling edge after the strobe is registered. This is at most 2×D+1 master cycles after the strobe edge, where D is the divider in force before the frame.
- R9: A strobe that arrives while a frame is shifting or waiting to start sets `overrun`. The newest words replace the words that have not been sent.
- R10: `overrun` stays set until `ovr_clr` or `rst` is asserted. If a set and a clear fall in the same cycle, the set wins.
- R11: Changes to `cfg_div`, `cfg_tdm` or `cfg_pkt` made during a frame do not affect that frame. They are taken up at the next frame start.
- R12: A pending frame starts on the `dclk` falling edge right after the last bit of the current frame, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle conversion-ready strobe |
| conv_data | input | NUM_LANES×8×40 | Channel words, 40 bits each, word k at bits k×40+39..k×40 |
| cfg_div | input | DIV_W | Bit clock divider |
| cfg_tdm | input | 2 | Channels per line select |
| cfg_pkt | input | 1 | Packet length select |
| ovr_clr | input | 1 | Clears the overrun flag |
| dclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync pulse |
| dout | output | NUM_LANES | Serial data lines |
| overrun | output | 1 | Sticky lost-data flag |

## Verification
Each frame's bits become due one per `dclk` rising edge. The first bit comes on the rise that follows the starting fall, which is itself at most 2×D+1 master cycles after the strobe. The scoreboard therefore indexes frame bits by counting `dclk` rises from the `fsync` rise instead of counting master cycles, and it samples on the falling master edge so that outputs updated at the rising edge have settled. The overrun flag is due one master cycle after the offending strobe and is read at the next falling master edge. The spacing between rises is checked against 2×D from the second bit onward, because the first half-period of a frame may still run at the previous divider.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;

    localparam int SLOTS_MAX = 8;
    localparam int WORD_W    = 40;
    localparam int SLOT_W    = $clog2(SLOTS_MAX);
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int PKT_SHORT = 24;
    localparam int PKT_LONG  = 40;

    typedef enum logic [1:0] {
        TDM_X1 = 2'd0,
        TDM_X2 = 2'd1,
        TDM_X4 = 2'd2,
        TDM_X8 = 2'd3
    } tdm_sel_e;

    typedef enum logic {
        PKT_24 = 1'b0,
        PKT_40 = 1'b1
    } pkt_sel_e;

    typedef struct packed {
        tdm_sel_e tdm;
        pkt_sel_e pkt;
    } frame_fmt_t;

    // number of slots on one line for a given select
    function automatic int unsigned tdm_slots(tdm_sel_e s);
        return 32'd1 << s;
    endfunction

    // bit index launched first in a packet (MSB first)
    function automatic logic [BIT_W-1:0] first_bit(pkt_sel_e p);
        return (p == PKT_40) ? BIT_W'(PKT_LONG - 1) : BIT_W'(PKT_SHORT - 1);
    endfunction

endpackage

// File: rtl/tdm_clkdiv.sv
module tdm_clkdiv #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             dclk,
    output logic             fall_evt
);

    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] div_eff;
    logic             tog;

    always_comb begin
        div_eff  = (div == '0) ? DIV_W'(1) : div;
        tog      = (hcnt >= div_eff - DIV_W'(1));
        fall_evt = tog & dclk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            dclk <= 1'b0;
        end else if (tog) begin
            hcnt <= '0;
            dclk <= ~dclk;
        end else begin
            hcnt <= hcnt + DIV_W'(1);
        end
    end

    // half-period counter never passes the active divider
    assert_half_bound_R1: assert property (@(posedge clk) disable iff (rst)
        hcnt < div_eff);

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_fsync_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_evt,
    input  logic              conv_valid,
    input  logic              ovr_clr,
    input  logic [DIV_W-1:0]  cfg_div,
    input  frame_fmt_t        cfg_fmt,
    output logic              start,
    output logic              busy,
    output logic              fsync,
    output logic              overrun,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bitpos,
    output logic [DIV_W-1:0]  act_div,
    output frame_fmt_t        act_fmt
);

    logic              pend;
    logic              last;
    logic [SLOT_W-1:0] last_slot;

    always_comb begin
        last_slot = SLOT_W'(tdm_slots(act_fmt.tdm) - 1);
        last      = busy && (slot == last_slot) && (bitpos == '0);
        start     = fall_evt && pend && (!busy || last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (conv_valid)      pend <= 1'b1;
            else if (start)      pend <= 1'b0;
            if (conv_valid && (busy || pend)) overrun <= 1'b1;
            else if (ovr_clr)                 overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            fsync   <= 1'b0;
            slot    <= '0;
            bitpos  <= '0;
            act_div <= DIV_W'(1);
            act_fmt <= '{tdm: TDM_X1, pkt: PKT_24};
        end else begin
            if (fall_evt) fsync <= start;
            if (start) begin
                busy    <= 1'b1;
                slot    <= '0;
                bitpos  <= first_bit(cfg_fmt.pkt);
                act_div <= cfg_div;
                act_fmt <= cfg_fmt;
            end else if (fall_evt && busy) begin
                if (last) begin
                    busy <= 1'b0;
                end else if (bitpos == '0) begin
                    slot   <= slot + SLOT_W'(1);
                    bitpos <= first_bit(act_fmt.pkt);
                end else begin
                    bitpos <= bitpos - BIT_W'(1);
                end
            end
        end
    end

    assert_ovr_set_R9: assert property (@(posedge clk) disable iff (rst)
        conv_valid && (busy || pend) |=> overrun);

    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun && !ovr_clr |=> overrun);

    assert_fmt_hold_R11: assert property (@(posedge clk) disable iff (rst)
        busy && !start |=> $stable(act_fmt) && $stable(act_div));

endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
    import tdm_fsync_pkg::*;
(
    input  logic                        clk,
    input  logic                        conv_valid,
    input  logic                        start,
    input  logic                        busy,
    input  logic [SLOTS_MAX*WORD_W-1:0] words,
    input  logic [SLOT_W-1:0]           slot,
    input  logic [BIT_W-1:0]            bitpos,
    output logic                        dout
);

    logic [SLOTS_MAX-1:0][WORD_W-1:0] pend_w;
    logic [SLOTS_MAX-1:0][WORD_W-1:0] act_w;

    always_ff @(posedge clk) begin
        if (conv_valid) pend_w <= words;
        if (start)      act_w  <= pend_w;
    end

    assign dout = busy & act_w[slot][bitpos];

endmodule

// File: rtl/tdm_fsync_tx.sv
module tdm_fsync_tx
    import tdm_fsync_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int DIV_W     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  conv_valid,
    input  logic [NUM_LANES*SLOTS_MAX*WORD_W-1:0] conv_data,
    input  logic [DIV_W-1:0]                      cfg_div,
    input  logic [1:0]                            cfg_tdm,
    input  logic                                  cfg_pkt,
    input  logic                                  ovr_clr,
    output logic                                  dclk,
    output logic                                  fsync,
    output logic [NUM_LANES-1:0]                  dout,
    output logic                                  overrun
);

    localparam int LANE_W = SLOTS_MAX * WORD_W;

    frame_fmt_t        cfg_fmt;
    frame_fmt_t        act_fmt;
    logic [DIV_W-1:0]  act_div;
    logic              fall_evt;
    logic              start;
    logic              busy;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitpos;

    always_comb begin
        cfg_fmt.tdm = tdm_sel_e'(cfg_tdm);
        cfg_fmt.pkt = pkt_sel_e'(cfg_pkt);
    end

    tdm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .div      (act_div),
        .dclk     (dclk),
        .fall_evt (fall_evt)
    );

    tdm_frame_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fall_evt   (fall_evt),
        .conv_valid (conv_valid),
        .ovr_clr    (ovr_clr),
        .cfg_div    (cfg_div),
        .cfg_fmt    (cfg_fmt),
        .start      (start),
        .busy       (busy),
        .fsync      (fsync),
        .overrun    (overrun),
        .slot       (slot),
        .bitpos     (bitpos),
        .act_div    (act_div),
        .act_fmt    (act_fmt)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        tdm_lane u_lane (
            .clk        (clk),
            .conv_valid (conv_valid),
            .start      (start),
            .busy       (busy),
            .words      (conv_data[l*LANE_W +: LANE_W]),
            .slot       (slot),
            .bitpos     (bitpos),
            .dout       (dout[l])
        );
    end

    assert_dout_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> $fell(dclk));

    assert_fsync_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync) |-> $fell(dclk));

    assert_fsync_first_R6: assert property (@(posedge clk) disable iff (rst)
        fsync |-> busy && (slot == '0) && (bitpos == first_bit(act_fmt.pkt)));

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dout == '0) && !fsync);

endmodule

// File: tb/tdm_fsync_tx_tb.sv
module tdm_fsync_tx_tb;
    import tdm_fsync_pkg::*;

    localparam int NL    = 2;
    localparam int DIV_W = 4;
    localparam int DW    = NL * SLOTS_MAX * WORD_W;

    typedef struct {
        int             tdm_n;
        int             pkt_n;
        int             div_n;
        bit             b2b;
        logic [DW-1:0]  data;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             conv_valid = 1'b0;
    logic [DW-1:0]    conv_data = '0;
    logic [DIV_W-1:0] cfg_div = DIV_W'(1);
    logic [1:0]       cfg_tdm = 2'd0;
    logic             cfg_pkt = 1'b0;
    logic             ovr_clr = 1'b0;
    logic             dclk;
    logic             fsync;
    logic [NL-1:0]    dout;
    logic             overrun;

    tdm_fsync_tx #(.NUM_LANES(NL), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
        .cfg_div(cfg_div), .cfg_tdm(cfg_tdm), .cfg_pkt(cfg_pkt), .ovr_clr(ovr_clr),
        .dclk(dclk), .fsync(fsync), .dout(dout), .overrun(overrun)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // scoreboard state
    item_t         q[$];
    item_t         cur;
    bit            in_frame = 1'b0;
    bit            prev_dclk = 1'b0;
    logic          prev_fsync = 1'b0;
    logic [NL-1:0] prev_dout = '0;
    int gap = 0, rise_idx = 0, last_end = -10, bitn = 0, total = 0;
    int mism[NL];
    int per_err = 0, r2_err = 0, idle_err = 0, fsync_mid = 0;

    // monitor: pops expected frames and compares on every dclk rise
    always @(negedge clk) begin
        if (rst) begin
            in_frame   = 1'b0;
            prev_dclk  = 1'b0;
            prev_dout  = '0;
            prev_fsync = 1'b0;
            gap        = 0;
        end else begin
            gap++;
            if ((dout !== prev_dout || fsync !== prev_fsync) && !(prev_dclk && !dclk))
                r2_err++;
            if (dclk && !prev_dclk) begin
                rise_idx++;
                if (fsync) begin
                    if (in_frame) fsync_mid++;
                    if (q.size() == 0) begin
                        check(1'b0, "R8", "actual frame start, expected none (queue empty)");
                        in_frame = 1'b0;
                    end else begin
                        cur = q.pop_front();
                        if (cur.b2b)
                            check(rise_idx == last_end + 1, "R12",
                                $sformatf("start rise actual %0d expected %0d", rise_idx, last_end + 1));
                        in_frame = 1'b1;
                        bitn = 0;
                        total = cur.tdm_n * cur.pkt_n;
                        per_err = 0;
                        for (int l = 0; l < NL; l++) mism[l] = 0;
                    end
                end else if (!in_frame && dout != '0) begin
                    idle_err++;
                end
                if (in_frame) begin
                    if (bitn >= 1 && gap != 2 * cur.div_n) per_err++;
                    for (int l = 0; l < NL; l++) begin
                        int idx;
                        idx = (l * SLOTS_MAX + bitn / cur.pkt_n) * WORD_W
                              + (cur.pkt_n - 1 - bitn % cur.pkt_n);
                        if (dout[l] !== cur.data[idx]) mism[l]++;
                    end
                    bitn++;
                    if (bitn == total) begin
                        in_frame = 1'b0;
                        last_end = rise_idx;
                        for (int l = 0; l < NL; l++)
                            check(mism[l] == 0, "R3 R4 R5",
                                $sformatf("lane %0d tdm %0d pkt %0d: actual %0d bad bits, expected 0",
                                          l, cur.tdm_n, cur.pkt_n, mism[l]));
                        check(per_err == 0, "R1 R11",
                            $sformatf("div %0d: actual %0d wrong periods, expected 0", cur.div_n, per_err));
                    end
                end
                gap = 0;
            end
            prev_dclk  = dclk;
            prev_dout  = dout;
            prev_fsync = fsync;
        end
    end

    int prev_div = 1;

    // driver: sets config, loads words, pushes expectation, pulses the strobe
    task automatic send(input int div, input int tsel, input int psel,
                        input bit b2b, input bit push, input bit measure);
        item_t it;
        int    d, c, bound;
        @(negedge clk);
        cfg_div = DIV_W'(div);
        cfg_tdm = 2'(tsel);
        cfg_pkt = psel[0];
        for (int i = 0; i < DW; i++) conv_data[i] = 1'($urandom_range(0, 1));
        d = (div == 0) ? 1 : div;
        it.tdm_n = 1 << tsel;
        it.pkt_n = psel ? PKT_LONG : PKT_SHORT;
        it.div_n = d;
        it.b2b   = b2b;
        it.data  = conv_data;
        if (push) q.push_back(it);
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        if (measure) begin
            bound = 2 * ((prev_div > d) ? prev_div : d) + 1;
            c = 1;
            while (!fsync) begin
                @(negedge clk);
                c++;
            end
            check(c >= 2 && c <= bound, "R8",
                $sformatf("latency actual %0d, expected 2..%0d", c, bound));
        end
        if (push) prev_div = d;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || in_frame) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dout == '0 && !fsync && !overrun, "R7",
            $sformatf("reset dout=%0h fsync=%0b ovr=%0b, expected 0 0 0", dout, fsync, overrun));

        send(1, 0, 0, 0, 1, 1); wait_idle();
        check(!overrun, "R9", $sformatf("spaced frames overrun actual %0b expected 0", overrun));
        send(2, 1, 1, 0, 1, 1); wait_idle();
        send(1, 2, 0, 0, 1, 1); wait_idle();
        send(1, 3, 1, 0, 1, 1); wait_idle();
        send(0, 1, 0, 0, 1, 1); wait_idle();

        // R11: change every setting while the frame shifts
        send(2, 1, 0, 0, 1, 1);
        @(negedge clk);
        cfg_div = DIV_W'(3); cfg_tdm = 2'd3; cfg_pkt = 1'b1;
        wait_idle();

        // R9/R12: two strobes during a long frame, only the last one survives
        send(1, 3, 1, 0, 1, 1);
        repeat (60) @(negedge clk);
        check(!overrun, "R9", $sformatf("busy no strobe overrun actual %0b expected 0", overrun));
        send(1, 3, 1, 0, 0, 0);
        check(overrun, "R9", $sformatf("strobe while busy overrun actual %0b expected 1", overrun));
        repeat (40) @(negedge clk);
        send(1, 3, 1, 1, 1, 0);
        wait_idle();
        check(overrun, "R10", $sformatf("sticky overrun actual %0b expected 1", overrun));
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(!overrun, "R10", $sformatf("after clear overrun actual %0b expected 0", overrun));

        // R10: reset also clears the flag
        send(1, 3, 1, 0, 1, 0);
        send(1, 3, 1, 0, 0, 0);
        check(overrun, "R9", $sformatf("pending replaced overrun actual %0b expected 1", overrun));
        rst = 1'b1;
        q.delete();
        repeat (2) @(negedge clk);
        check(!overrun && dout == '0 && !fsync, "R10",
            $sformatf("reset ovr=%0b dout=%0h fsync=%0b, expected 0 0 0", overrun, dout, fsync));
        rst = 1'b0;
        repeat (4) @(negedge clk);

        check(r2_err == 0, "R2", $sformatf("changes off falling edge actual %0d expected 0", r2_err));
        check(idle_err == 0, "R7", $sformatf("idle high bits actual %0d expected 0", idle_err));
        check(fsync_mid == 0, "R6", $sformatf("fsync inside frame actual %0d expected 0", fsync_mid));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R8", "watchdog expired: actual hang, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule